// File: doc/BRIEF.md
# Programmable Periodic Interval Timer

This block is an interval timer clocked directly by the core clock. Software sets it up through four word-addressed registers on a simple write/read bus: a control word, the live down-counter, a reload period and a prescale value. While enabled, the prescaler lets the down-counter step once every `scale + 1` core clocks. When a step finds the counter at zero, the timer expires and raises a latched interrupt flag.

In auto-reload mode the counter is refilled from the period register on the expiring step, so interrupts repeat every `(period + 1) * (scale + 1)` clocks. In one-shot mode the counter parks at zero after the first expiry. It stays there until software rewrites the count or the period.

The flag is not write-one-to-clear. Software clears it by a read-modify-write of the control word with the flag bit written as zero. The interrupt output is the flag gated by the enable bit. Writes to the count, period and scale registers interact, as set out in the requirements below.

Top module: `interval_timer`

## Requirements
- R1: After reset, all four registers read zero and `irq` is low.
- R2: Register addresses are 0 control, 1 count, 2 period and 3 scale. Period and scale read back the value last written. A scale write restarts the prescaler from the new value.
- R3: Control bit 0 is enable, bit 1 is auto-reload and bit 2 is the interrupt flag. After a control write that sets enable with the counter holding P and scale S, the flag first rises exactly (P+1)*(S+1) clock edges after the edge that captured the write.
- R4: With auto-reload set, the expiring step loads the counter from the period register. Each later expiry follows the previous one by exactly (period+1)*(scale+1) edges.
- R5: A control write with bit 2 equal to 0 clears the flag. A write with bit 2 equal to 1 leaves the flag as it was, so it can neither set nor clear it. An expiry in the same cycle as a clearing write wins.
- R6: `irq` is high exactly when the flag and the enable bit are both set. Clearing enable with bit 2 equal to 1 keeps the flag while `irq` goes low.
- R7: A count write while enable is clear loads the counter directly. A count write while enable is set is ignored.
- R8: A period write while enable is clear also loads the counter with the same value.
- R9: With auto-reload clear, an expiry sets the flag and leaves the counter at zero. No further expiry occurs until the count or period is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request, flag AND enable |

## Verification
A wrong prescaler or counter value shows up as an expiry that arrives early or late. The bench measures the gap in edges for every scale and period pair in a small sweep, so one cycle of error is visible at the first interrupt. A fault in the flag update shows up in `irq` and in control bit 2 on the next readback. This covers a flag that clears on a written one, or one that loses a collision with expiry. A counter that accepts writes while running, or that keeps counting after a one-shot expiry, reads back a wrong count within a few cycles.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam logic [1:0] ADDR_CTL = 2'd0;
    localparam logic [1:0] ADDR_CNT = 2'd1;
    localparam logic [1:0] ADDR_PER = 2'd2;
    localparam logic [1:0] ADDR_SCL = 2'd3;

    localparam int BIT_EN   = 0;
    localparam int BIT_RL   = 1;
    localparam int BIT_FLAG = 2;
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [SCALE_W-1:0] scale,
    input  logic               restart,
    input  logic [SCALE_W-1:0] restart_val,
    output logic               tick
);
    typedef struct packed {
        logic [SCALE_W-1:0] left;
    } pre_state_t;

    pre_state_t pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        tick  = 1'b0;
        if (restart) begin
            pre_d.left = restart_val;
        end else if (!run) begin
            pre_d.left = scale;
        end else if (pre_q.left == '0) begin
            tick       = 1'b1;
            pre_d.left = scale;
        end else begin
            pre_d.left = pre_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/timer_downcount.sv
module timer_downcount #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             auto_rl,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             done,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic             parked;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (load) begin
            cnt_d.value  = load_val;
            cnt_d.parked = 1'b0;
        end else if (tick && !cnt_q.parked) begin
            if (cnt_q.value == '0) begin
                expire = 1'b1;
                if (auto_rl) begin
                    cnt_d.value = period;
                end else begin
                    cnt_d.parked = 1'b1;
                end
            end else begin
                cnt_d.value = cnt_q.value - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q.value;
    assign done = cnt_q.parked;
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int CNT_W   = 32,
    parameter int SCALE_W = 8,
    parameter int BUS_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             irq
);
    import timer_pkg::*;

    localparam int CTL_W = 3;

    typedef struct packed {
        logic               en;
        logic               rl;
        logic               flag;
        logic [CNT_W-1:0]   period;
        logic [SCALE_W-1:0] scale;
    } top_state_t;

    top_state_t top_d, top_q;

    logic             wr_ctl, wr_cnt, wr_per, wr_scl;
    logic             tick, load, done, expire;
    logic [CNT_W-1:0] cnt;

    assign wr_ctl = wr_en && (addr == ADDR_CTL);
    assign wr_cnt = wr_en && (addr == ADDR_CNT);
    assign wr_per = wr_en && (addr == ADDR_PER);
    assign wr_scl = wr_en && (addr == ADDR_SCL);

    assign load = !top_q.en && (wr_cnt || wr_per);

    timer_prescaler #(.SCALE_W(SCALE_W)) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (top_q.en),
        .scale       (top_q.scale),
        .restart     (wr_scl),
        .restart_val (wdata[SCALE_W-1:0]),
        .tick        (tick)
    );

    timer_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (load),
        .load_val (wdata[CNT_W-1:0]),
        .auto_rl  (top_q.rl),
        .period   (top_q.period),
        .cnt      (cnt),
        .done     (done),
        .expire   (expire)
    );

    always_comb begin
        top_d = top_q;
        if (wr_ctl) begin
            top_d.en   = wdata[BIT_EN];
            top_d.rl   = wdata[BIT_RL];
            top_d.flag = top_q.flag & wdata[BIT_FLAG];
        end
        if (wr_per) top_d.period = wdata[CNT_W-1:0];
        if (wr_scl) top_d.scale  = wdata[SCALE_W-1:0];
        if (expire) top_d.flag   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    always_comb begin
        unique case (addr)
            ADDR_CTL: rdata = BUS_W'({top_q.flag, top_q.rl, top_q.en});
            ADDR_CNT: rdata = BUS_W'(cnt);
            ADDR_PER: rdata = BUS_W'(top_q.period);
            default:  rdata = BUS_W'(top_q.scale);
        endcase
    end

    assign irq = top_q.flag & top_q.en;

    logic unused_ok;
    assign unused_ok = &{1'b0, done, CTL_W[0]};
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
    parameter int CNT_W   = 32,
    parameter int SCALE_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [1:0]         addr,
    input logic [SCALE_W-1:0] wd_scale,
    input logic               wd_flag,
    input logic               en,
    input logic               rl,
    input logic               flag,
    input logic [CNT_W-1:0]   cnt,
    input logic [CNT_W-1:0]   period,
    input logic [SCALE_W-1:0] scale,
    input logic               tick,
    input logic               done
);
    import timer_pkg::*;

    assert_scale_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_SCL) |=> (scale == $past(wd_scale)));

    assert_flag_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(tick));

    assert_reload_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '0 && rl && !done) |=> (cnt == $past(period) && flag));

    assert_flag_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && wr_en && addr == ADDR_CTL && wd_flag) |=> flag);

    assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && wr_en && addr == ADDR_CTL && !wd_flag && !(tick && cnt == '0 && !done))
        |=> !flag);

    assert_count_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_en && addr == ADDR_CNT && !tick) |=> $stable(cnt));

    assert_oneshot_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(wr_en && (addr == ADDR_CNT || addr == ADDR_PER)))
        |=> (cnt == '0 && done));
endmodule

bind interval_timer interval_timer_chk #(.CNT_W(CNT_W), .SCALE_W(SCALE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wd_scale (wdata[SCALE_W-1:0]),
    .wd_flag  (wdata[timer_pkg::BIT_FLAG]),
    .en       (top_q.en),
    .rl       (top_q.rl),
    .flag     (top_q.flag),
    .cnt      (cnt),
    .period   (top_q.period),
    .scale    (top_q.scale),
    .tick     (tick),
    .done     (done)
);

// File: tb/test_interval_timer.sv
`timescale 1ns/1ps
module test_interval_timer;
    localparam int BUS_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       addr = 2'd0;
    logic [BUS_W-1:0] wdata = '0;
    logic [BUS_W-1:0] rdata;
    logic             irq;

    int vectors = 0;
    int fails   = 0;
    bit ended   = 1'b0;

    interval_timer i_interval_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [BUS_W-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [BUS_W-1:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!irq && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [BUS_W-1:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", irq, 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reg", v, 0);
        end
        @(negedge clk);

        // R2 R3 R4 R5 R8: sweep of scale and period
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 6; p++) begin
                int m;
                m = (p + 1) * (s + 1);
                wr(2'd0, 0);
                wr(2'd3, s);
                wr(2'd2, p);
                rd(2'd1, v); check("R8 count", v, p);
                rd(2'd2, v); check("R2 period", v, p);
                rd(2'd3, v); check("R2 scale", v, s);
                @(negedge clk);
                wr(2'd0, 3);
                wait_irq(n);
                check("R3 first expiry", n, m);
                wr(2'd0, 3);
                if (m > 1) check("R5 cleared", irq, 0);
                n = 1;
                while (!irq && n < 1000) begin
                    @(negedge clk);
                    n++;
                end
                check("R4 period", n, m);
            end
        end

        // R6 and R5: gating, writing one keeps the flag
        wr(2'd0, 0);
        wr(2'd3, 0);
        wr(2'd2, 3);
        wr(2'd0, 3);
        wait_irq(n);
        check("R6 irq set", irq, 1);
        wr(2'd0, 4);
        check("R6 gated off", irq, 0);
        rd(2'd0, v); check("R5 flag kept", v, 4);
        @(negedge clk);
        wr(2'd0, 5);
        check("R6 gated on", irq, 1);
        wr(2'd0, 0);
        wr(2'd0, 4);
        rd(2'd0, v); check("R5 one does not set", v, 0);
        @(negedge clk);

        // R7: count writes
        wr(2'd3, 3);
        wr(2'd2, 5);
        wr(2'd0, 3);
        wr(2'd1, 'hAB);
        rd(2'd1, v); check("R7 running ignored", (v <= 5) ? 1 : 0, 1);
        @(negedge clk);
        wr(2'd0, 0);
        wr(2'd1, 'h1F);
        rd(2'd1, v); check("R7 stopped load", v, 'h1F);
        @(negedge clk);

        // R9: one-shot
        wr(2'd3, 1);
        wr(2'd2, 2);
        wr(2'd0, 1);
        wait_irq(n);
        check("R9 one-shot expiry", n, 6);
        wr(2'd0, 1);
        repeat (20) @(negedge clk);
        check("R9 no re-fire", irq, 0);
        rd(2'd1, v); check("R9 parked count", v, 0);
        @(negedge clk);
        wr(2'd0, 0);
        wr(2'd1, 0);
        wr(2'd0, 1);
        wait_irq(n);
        check("R9 rearmed", n, 2);

        finish_run();
    end
endmodule